// File: doc/BRIEF.md
# Address-Translation Cache with Hardware Page-Table Refill

This block turns virtual addresses into physical addresses for a processor core. It keeps a small, fully associative set of recent translations. Each cached entry holds a virtual page number, a page frame number, a read permission and a write permission. When a request finds its page in the set, the block answers in the next cycle. The answer is either a physical address, or a protection fault if the access type is not permitted.

When the page is not cached, the block walks a one-level linear page table in memory. It forms the table-entry address from a base input and the page number, and issues one read on a request/valid memory port. It then examines the returned entry. A missing mapping yields a segmentation fault. A mapping that forbids the access yields a protection fault. A usable mapping is written into the cache, and the same request is looked up again, which now hits.

While a refill is outstanding, the request port is held busy. A flush input discards every cached translation. When every slot is occupied, new translations take turns overwriting slots under a rotating pointer.

Top module: `tlb_walker`

## Requirements
- R1: The page number is the virtual address with its low OFF_W bits removed, and the page offset is those low OFF_W bits (defaults: 8-bit address, 4-bit offset, 4-bit page number). A successful translation returns `{frame, offset}`.
- R2: A request whose page is already cached answers one cycle after acceptance and makes no memory read.
- R3: A cached page whose permission bit for the requested access is clear answers with a protection fault and a zero address, without a memory read.
- R4: On a miss, `mem_req` rises with `mem_addr = ptbr + page * PTE_BYTES` (default 2 bytes per entry). Address and request stay steady until `mem_valid` is seen.
- R5: Table-entry layout, with the default width of 11 bits: bit 10 = present, bit 9 = write allowed, bit 8 = read allowed, bits 7:0 = frame. An entry with present clear gives a segmentation fault, whatever its permission bits say.
- R6: A present entry that forbids the access gives a protection fault, and the entry is not cached. Repeating the request walks again.
- R7: A present, permitted entry is cached and the request is replayed internally. The response carries the translated address two cycles after `mem_valid` is sampled.
- R8: Reset and a one-cycle `flush` pulse both leave no translation cached, so the next access to any page walks.
- R9: Free slots are filled lowest index first. With all slots full, a refill overwrites the slot under a round-robin pointer, which then advances by one.
- R10: `req_ready` is low from the cycle a walk starts until its response. A request held during that time is neither accepted nor answered.
- R11: `rsp_fault` encodings: 0 = none, 1 = protection, 2 = segmentation. Code 3 never appears, and `rsp_pa` is zero on any fault.
- R12: Reading ten 4-byte words from address 100 upward walks the table only at pages 6, 7 and 8. The other seven reads hit.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard all cached translations |
| ptbr | input | MA_W | Byte address of page-table entry 0 |
| req_valid | input | 1 | Translation request present |
| req_va | input | VA_W | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_ready | output | 1 | Block can accept a request this cycle |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_pa | output | OFF_W+PFN_W | Physical address, zero on fault |
| rsp_fault | output | 2 | Fault code (see R11) |
| mem_req | output | 1 | Table-entry read request |
| mem_addr | output | MA_W | Table-entry byte address |
| mem_valid | input | 1 | Read data returned |
| mem_data | input | PFN_W+3 | Table entry |

## Verification
The bound checker watches several properties on every cycle. It checks that the port is busy whenever a read is outstanding, and that the read address holds until data returns. It checks the fault encoding and the zero address on faults. It checks that a segmentation fault always follows a returned read, that installs happen only on a read return, that a flush empties the cache, and that no page ever matches two slots. Some behaviour needs known page-table contents, so only the bench scenarios can show it. This covers the exact translated address and whether a request hit or walked, including the ten-word array pattern. It also covers the fault type chosen for each kind of entry, the fact that a denied entry is never cached, and which slot round-robin eviction overwrites.

// File: rtl/tlbw_pkg.sv
package tlbw_pkg;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_PROT = 2'd1,
    FLT_SEG  = 2'd2
  } fault_e;

  // Permission check shared by the hit path and the refill path.
  function automatic logic perm_ok(input logic rd_ok, input logic wr_ok, input logic is_wr);
    return is_wr ? wr_ok : rd_ok;
  endfunction

endpackage

// File: rtl/tlbw_cam.sv
module tlbw_cam #(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 4,
  parameter int PFN_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               lk_hit,
  output logic [PFN_W-1:0]   lk_pfn,
  output logic               lk_rd,
  output logic               lk_wr,
  output logic [ENTRIES-1:0] hit_vec,
  output logic [ENTRIES-1:0] valid_mask,
  input  logic               ins_en,
  input  logic [IDX_W-1:0]   ins_idx,
  input  logic [VPN_W-1:0]   ins_vpn,
  input  logic [PFN_W-1:0]   ins_pfn,
  input  logic               ins_rd,
  input  logic               ins_wr
);

  logic [PFN_W-1:0] pfn_a [ENTRIES];
  logic             rd_a  [ENTRIES];
  logic             wr_a  [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic             v_q;
    logic [VPN_W-1:0] tag_q;
    logic [PFN_W-1:0] pfn_q;
    logic             rd_q;
    logic             wr_q;
    logic             sel;

    assign sel = ins_en && (ins_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     v_q <= 1'b0;
      else if (flush) v_q <= 1'b0;
      else if (sel)   v_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q <= ins_vpn;
        pfn_q <= ins_pfn;
        rd_q  <= ins_rd;
        wr_q  <= ins_wr;
      end
    end

    assign valid_mask[g] = v_q;
    assign hit_vec[g]    = v_q && (tag_q == lk_vpn);
    assign pfn_a[g]      = pfn_q;
    assign rd_a[g]       = rd_q;
    assign wr_a[g]       = wr_q;
  end

  always_comb begin
    lk_pfn = '0;
    lk_rd  = 1'b0;
    lk_wr  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) begin
        lk_pfn = lk_pfn | pfn_a[i];
        lk_rd  = lk_rd  | rd_a[i];
        lk_wr  = lk_wr  | wr_a[i];
      end
    end
  end

  assign lk_hit = |hit_vec;

endmodule

// File: rtl/tlbw_victim.sv
module tlbw_victim #(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_mask,
  input  logic               ins_en,
  output logic [IDX_W-1:0]   victim_idx
);

  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             full;

  // Lowest-index free slot: scan downward so the lowest assignment wins.
  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_mask[i]) free_idx = IDX_W'(i);
    end
  end

  assign full       = &valid_mask;
  assign victim_idx = full ? rr_q : free_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (ins_en && full) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

endmodule

// File: rtl/tlbw_walk_ctrl.sv
module tlbw_walk_ctrl
  import tlbw_pkg::*;
#(
  parameter int VA_W      = 8,
  parameter int OFF_W     = 4,
  parameter int PFN_W     = 8,
  parameter int MA_W      = 16,
  parameter int PTE_BYTES = 2,
  localparam int VPN_W    = VA_W - OFF_W,
  localparam int PA_W     = PFN_W + OFF_W,
  localparam int PTE_W    = PFN_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MA_W-1:0]   ptbr,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_va,
  input  logic              req_write,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_pa,
  output logic [1:0]        rsp_fault,
  output logic              mem_req,
  output logic [MA_W-1:0]   mem_addr,
  input  logic              mem_valid,
  input  logic [PTE_W-1:0]  mem_data,
  output logic [VPN_W-1:0]  lk_vpn,
  input  logic              lk_hit,
  input  logic [PFN_W-1:0]  lk_pfn,
  input  logic              lk_rd,
  input  logic              lk_wr,
  output logic              ins_en,
  output logic [VPN_W-1:0]  ins_vpn,
  output logic [PFN_W-1:0]  ins_pfn,
  output logic              ins_rd,
  output logic              ins_wr
);

  localparam logic [VA_W-1:0] OFF_MASK = VA_W'((1 << OFF_W) - 1);

  function automatic logic [VPN_W-1:0] vpn_of(input logic [VA_W-1:0] va);
    logic [VA_W-1:0] t;
    t = (va & ~OFF_MASK) >> OFF_W;
    return t[VPN_W-1:0];
  endfunction

  function automatic logic [OFF_W-1:0] off_of(input logic [VA_W-1:0] va);
    logic [VA_W-1:0] t;
    t = va & OFF_MASK;
    return t[OFF_W-1:0];
  endfunction

  function automatic logic [PA_W-1:0] make_pa(input logic [PFN_W-1:0] pfn,
                                              input logic [OFF_W-1:0] off);
    return (PA_W'(pfn) << OFF_W) | PA_W'(off);
  endfunction

  function automatic logic [MA_W-1:0] pte_addr(input logic [MA_W-1:0] base,
                                               input logic [VPN_W-1:0] vpn);
    return base + MA_W'(vpn) * MA_W'(PTE_BYTES);
  endfunction

  typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_REPLAY} st_e;

  st_e              st_q;
  logic [VA_W-1:0]  hold_va_q;
  logic             hold_wr_q;
  logic [VA_W-1:0]  cur_va;
  logic             cur_wr;
  logic             do_lookup;
  logic             walk_ret;
  logic             pte_present;
  logic             pte_wr;
  logic             pte_rd;
  logic             walk_ok;

  assign req_ready = (st_q == ST_IDLE);
  assign cur_va    = (st_q == ST_IDLE) ? req_va : hold_va_q;
  assign cur_wr    = (st_q == ST_IDLE) ? req_write : hold_wr_q;
  assign lk_vpn    = vpn_of(cur_va);
  assign do_lookup = (req_ready && req_valid) || (st_q == ST_REPLAY);

  assign pte_present = mem_data[PTE_W-1];
  assign pte_wr      = mem_data[PTE_W-2];
  assign pte_rd      = mem_data[PTE_W-3];
  assign walk_ret    = (st_q == ST_WALK) && mem_valid;
  assign walk_ok     = pte_present && perm_ok(pte_rd, pte_wr, hold_wr_q);

  assign ins_en  = walk_ret && walk_ok;
  assign ins_vpn = vpn_of(hold_va_q);
  assign ins_pfn = mem_data[PFN_W-1:0];
  assign ins_rd  = pte_rd;
  assign ins_wr  = pte_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      hold_va_q <= '0;
      hold_wr_q <= 1'b0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      rsp_valid <= 1'b0;
      rsp_pa    <= '0;
      rsp_fault <= FLT_NONE;
    end else begin
      rsp_valid <= 1'b0;
      case (st_q)
        ST_IDLE, ST_REPLAY: begin
          if (do_lookup) begin
            hold_va_q <= cur_va;
            hold_wr_q <= cur_wr;
            if (lk_hit) begin
              rsp_valid <= 1'b1;
              st_q      <= ST_IDLE;
              if (perm_ok(lk_rd, lk_wr, cur_wr)) begin
                rsp_fault <= FLT_NONE;
                rsp_pa    <= make_pa(lk_pfn, off_of(cur_va));
              end else begin
                rsp_fault <= FLT_PROT;
                rsp_pa    <= '0;
              end
            end else begin
              st_q     <= ST_WALK;
              mem_req  <= 1'b1;
              mem_addr <= pte_addr(ptbr, lk_vpn);
            end
          end
        end
        ST_WALK: begin
          if (mem_valid) begin
            mem_req <= 1'b0;
            if (!pte_present) begin
              rsp_valid <= 1'b1;
              rsp_fault <= FLT_SEG;
              rsp_pa    <= '0;
              st_q      <= ST_IDLE;
            end else if (!walk_ok) begin
              rsp_valid <= 1'b1;
              rsp_fault <= FLT_PROT;
              rsp_pa    <= '0;
              st_q      <= ST_IDLE;
            end else begin
              st_q <= ST_REPLAY;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tlb_walker.sv
module tlb_walker #(
  parameter int VA_W      = 8,
  parameter int OFF_W     = 4,
  parameter int PFN_W     = 8,
  parameter int ENTRIES   = 4,
  parameter int MA_W      = 16,
  parameter int PTE_BYTES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic [MA_W-1:0]         ptbr,
  input  logic                    req_valid,
  input  logic [VA_W-1:0]         req_va,
  input  logic                    req_write,
  output logic                    req_ready,
  output logic                    rsp_valid,
  output logic [OFF_W+PFN_W-1:0]  rsp_pa,
  output logic [1:0]              rsp_fault,
  output logic                    mem_req,
  output logic [MA_W-1:0]         mem_addr,
  input  logic                    mem_valid,
  input  logic [PFN_W+2:0]        mem_data
);

  localparam int VPN_W = VA_W - OFF_W;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [VPN_W-1:0]   lk_vpn;
  logic               lk_hit;
  logic [PFN_W-1:0]   lk_pfn;
  logic               lk_rd;
  logic               lk_wr;
  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] valid_mask;
  logic               ins_en;
  logic [IDX_W-1:0]   ins_idx;
  logic [VPN_W-1:0]   ins_vpn;
  logic [PFN_W-1:0]   ins_pfn;
  logic               ins_rd;
  logic               ins_wr;

  tlbw_walk_ctrl #(
    .VA_W(VA_W), .OFF_W(OFF_W), .PFN_W(PFN_W), .MA_W(MA_W), .PTE_BYTES(PTE_BYTES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ptbr(ptbr),
    .req_valid(req_valid), .req_va(req_va), .req_write(req_write), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_data(mem_data),
    .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_rd(lk_rd), .lk_wr(lk_wr),
    .ins_en(ins_en), .ins_vpn(ins_vpn), .ins_pfn(ins_pfn), .ins_rd(ins_rd), .ins_wr(ins_wr)
  );

  tlbw_cam #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)
  ) u_cam (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_rd(lk_rd), .lk_wr(lk_wr),
    .hit_vec(hit_vec), .valid_mask(valid_mask),
    .ins_en(ins_en), .ins_idx(ins_idx), .ins_vpn(ins_vpn), .ins_pfn(ins_pfn),
    .ins_rd(ins_rd), .ins_wr(ins_wr)
  );

  tlbw_victim #(
    .ENTRIES(ENTRIES)
  ) u_victim (
    .clk(clk), .rst_n(rst_n), .valid_mask(valid_mask), .ins_en(ins_en),
    .victim_idx(ins_idx)
  );

endmodule

// File: rtl/tlb_walker_checker.sv
module tlb_walker_checker #(
  parameter int MA_W    = 16,
  parameter int PA_W    = 12,
  parameter int ENTRIES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush,
  input logic               req_ready,
  input logic               mem_req,
  input logic               mem_valid,
  input logic [MA_W-1:0]    mem_addr,
  input logic               rsp_valid,
  input logic [PA_W-1:0]    rsp_pa,
  input logic [1:0]         rsp_fault,
  input logic [ENTRIES-1:0] hit_vec,
  input logic [ENTRIES-1:0] valid_mask,
  input logic               ins_en
);

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready); // R10

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr))); // R4

  AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'd0) |-> (rsp_pa == '0)); // R11

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault != 2'd3)); // R11

  AST_SEG_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'd2) |-> $past(mem_valid)); // R5

  AST_INSTALL_ON_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |-> (mem_req && mem_valid)); // R7

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_mask == '0)); // R8

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R2

endmodule

bind tlb_walker tlb_walker_checker #(
  .MA_W(MA_W), .PA_W(OFF_W + PFN_W), .ENTRIES(ENTRIES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .req_ready(req_ready),
  .mem_req(mem_req), .mem_valid(mem_valid), .mem_addr(mem_addr),
  .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
  .hit_vec(hit_vec), .valid_mask(valid_mask), .ins_en(ins_en)
);

// File: tb/tlb_walker_test.sv
`timescale 1ns/1ps
module tlb_walker_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [15:0] ptbr = 16'h1230;
  logic        req_valid = 1'b0;
  logic [7:0]  req_va = '0;
  logic        req_write = 1'b0;
  logic        req_ready;
  logic        rsp_valid;
  logic [11:0] rsp_pa;
  logic [1:0]  rsp_fault;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_valid = 1'b0;
  logic [10:0] mem_data = '0;

  int checks = 0;
  int fails  = 0;
  int walks  = 0;
  int addr_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tlb_walker uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .ptbr(ptbr),
    .req_valid(req_valid), .req_va(req_va), .req_write(req_write), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_data(mem_data)
  );

  // Page table: page F absent (no permissions), E read-only, D write-only, rest read/write.
  function automatic logic [7:0] frame_of(input int pg);
    return 8'((pg ^ 9) * 16 + pg);
  endfunction

  function automatic logic [10:0] entry_of(input int pg);
    logic p, w, r;
    p = (pg != 15);
    w = (pg != 14) && (pg != 15);
    r = (pg != 13) && (pg != 15);
    return {p, w, r, frame_of(pg)};
  endfunction

  // Memory model: answers each request one cycle later, checks the entry address (R4).
  always @(negedge clk) begin
    if (mem_req && !mem_valid) begin
      int pg;
      pg = (int'(mem_addr) - int'(ptbr)) / 2;
      if (pg < 0 || pg > 15 || (int'(mem_addr) - int'(ptbr)) % 2 != 0 ||
          (int'(req_va_hold) / 16) != pg) addr_err++;
      mem_data  = entry_of(pg & 15);
      mem_valid = 1'b1;
      walks++;
    end else begin
      mem_valid = 1'b0;
    end
  end

  logic [7:0] req_va_hold = '0;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic access(input bit wr, input logic [7:0] va,
                        output bit got, output logic [1:0] flt,
                        output logic [11:0] pa, output int nwalk);
    int w0;
    @(negedge clk);
    w0 = walks;
    req_va_hold = va;
    req_valid = 1'b1; req_va = va; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    got = 0;
    for (int i = 0; i < 20 && !got; i++) begin
      if (rsp_valid) begin
        got = 1; flt = rsp_fault; pa = rsp_pa;
      end else begin
        @(negedge clk);
      end
    end
    nwalk = walks - w0;
  endtask

  // Vector: {write, va, expect_walk, expect_fault}
  localparam int NV = 23;
  localparam logic [11:0] VEC [NV] = '{
    {1'b0, 8'h64, 1'b1, 2'd0},  // R12 a[0] page 6
    {1'b0, 8'h68, 1'b0, 2'd0},
    {1'b0, 8'h6C, 1'b0, 2'd0},
    {1'b0, 8'h70, 1'b1, 2'd0},  // R12 page 7
    {1'b0, 8'h74, 1'b0, 2'd0},
    {1'b0, 8'h78, 1'b0, 2'd0},
    {1'b0, 8'h7C, 1'b0, 2'd0},
    {1'b0, 8'h80, 1'b1, 2'd0},  // R12 page 8
    {1'b0, 8'h84, 1'b0, 2'd0},
    {1'b0, 8'h88, 1'b0, 2'd0},
    {1'b1, 8'h8C, 1'b0, 2'd0},  // R2 write hit
    {1'b0, 8'hE0, 1'b1, 2'd0},  // R7 read-only page installed
    {1'b1, 8'hE4, 1'b0, 2'd1},  // R3 protection on hit
    {1'b0, 8'hF0, 1'b1, 2'd2},  // R5 absent beats denied perms
    {1'b0, 8'hF8, 1'b1, 2'd2},  // R5 not cached
    {1'b0, 8'hD0, 1'b1, 2'd1},  // R6 denied on walk
    {1'b0, 8'hD4, 1'b1, 2'd1},  // R6 walks again
    {1'b1, 8'h24, 1'b1, 2'd0},  // R9 full: evicts slot 0 (page 6)
    {1'b0, 8'h7C, 1'b0, 2'd0},  // R9 page 7 survives
    {1'b0, 8'h60, 1'b1, 2'd0},  // R9 page 6 gone, evicts slot 1 (page 7)
    {1'b0, 8'h80, 1'b0, 2'd0},  // R9 page 8 survives
    {1'b0, 8'h70, 1'b1, 2'd0},  // R9 evicts slot 2 (page 8)
    {1'b0, 8'h84, 1'b1, 2'd0}   // R9 page 8 gone
  };

  function automatic logic [11:0] expect_pa(input logic [7:0] va);
    return 12'(int'(frame_of(int'(va) / 16)) * 16 + int'(va) % 16);
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin : main
    bit got;
    logic [1:0] flt;
    logic [11:0] pa;
    int nw;
    int w0;

    repeat (3) @(negedge clk);
    // R8 reset state
    check(req_ready == 1'b1, "R8 reset req_ready", int'(req_ready), 1);
    check(rsp_valid == 1'b0, "R8 reset rsp_valid", int'(rsp_valid), 0);
    check(mem_req == 1'b0, "R8 reset mem_req", int'(mem_req), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      logic [11:0] v;
      logic [11:0] epa;
      v = VEC[k];
      access(v[11], v[10:3], got, flt, pa, nw);
      epa = (v[1:0] == 2'd0) ? expect_pa(v[10:3]) : 12'h000;
      check(got, "R2 R7 response arrives", int'(got), 1);
      check(nw == int'(v[2]), "R2 R12 R6 walk count", nw, int'(v[2]));
      check(flt == v[1:0], "R3 R5 R6 R11 fault code", int'(flt), int'(v[1:0]));
      check(pa == epa, "R1 R7 R11 physical address", int'(pa), int'(epa));
    end

    // R10: request held during a walk is ignored
    @(negedge clk);
    w0 = walks;
    req_va_hold = 8'h93;
    req_valid = 1'b1; req_va = 8'h93; req_write = 1'b0;
    @(negedge clk);
    req_va = 8'h94; req_write = 1'b1;
    check(mem_req == 1'b1, "R10 walk started", int'(mem_req), 1);
    check(req_ready == 1'b0, "R10 busy during read", int'(req_ready), 0);
    @(negedge clk);
    check(req_ready == 1'b0, "R10 busy during replay", int'(req_ready), 0);
    check(rsp_valid == 1'b0, "R10 no early response", int'(rsp_valid), 0);
    req_valid = 1'b0;
    @(negedge clk);
    check(rsp_valid == 1'b1, "R7 replay response timing", int'(rsp_valid), 1);
    check(rsp_pa == expect_pa(8'h93), "R1 R7 replay address", int'(rsp_pa), int'(expect_pa(8'h93)));
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(rsp_valid == 1'b0, "R10 held request not answered", int'(rsp_valid), 0);
    end
    check(walks - w0 == 1, "R10 single walk", walks - w0, 1);

    // R8: flush empties the cache
    access(1'b0, 8'h95, got, flt, pa, nw);
    check(nw == 0, "R2 page 9 cached", nw, 0);
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    access(1'b0, 8'h95, got, flt, pa, nw);
    check(nw == 1, "R8 walk after flush", nw, 1);
    check(pa == expect_pa(8'h95), "R8 address after flush", int'(pa), int'(expect_pa(8'h95)));
    access(1'b0, 8'h9A, got, flt, pa, nw);
    check(nw == 0, "R8 refilled page hits", nw, 0);

    check(addr_err == 0, "R4 entry address", addr_err, 0);

    done = 1;
    report();
  end

endmodule